// File: doc/BRIEF.md
# Region Access Guard

The guard sits in front of a memory and decides, for every access, whether the requester may perform it. Software programs up to 24 address windows. Each window has an inclusive lower bound, an inclusive upper bound and a policy word. The policy word carries a 3-bit rule for each of eight requester domains, plus a freeze flag. An access presents its address, its domain number, its direction and whether it is secure. The guard answers allow or deny in the same cycle.

When a denied access occurs, the guard records its identifier and its direction in a status word. It keeps that record until software writes a clear command.

Programming uses a plain register port. Writes take effect on the clock edge. Reads return data combinationally for the address presented.

Top module: `regionGuard`

## Requirements
- R1: A window covers an access address A when lower <= A and A <= upper. Both bounds are inclusive. An address one below the lower bound or one above the upper bound is not covered.
- R2: When several windows cover an address, the window with the smallest index alone decides the result.
- R3: An access that no window covers is allowed.
- R4: Domain d takes its rule from policy bits [3d+2:3d]. The rules grant these rights:
  - 0: everything.
  - 1: secure read and secure write only.
  - 2: secure read and write, plus non-secure read.
  - 3: secure read and write, plus non-secure write.
  - 4: read only, for both secure and non-secure accesses.
  - 5: nothing.
  - 6: secure read, plus non-secure read and write.
  - 7: nothing.
- R5: The register map is:
  - Lower bound of window r: byte offset 0x100+4r.
  - Upper bound of window r: byte offset 0x200+4r.
  - Policy word of window r: byte offset 0x300+4r. Only bits 26 and 23:0 are stored; the other bits read back as 0.
  - Status word: offset 0x000.
  Each register reads back what was last written to it.
- R6: When bit 26 of a window's policy word is 1, register writes to that window's lower bound, upper bound and policy word are ignored.
- R7: A denied access with the status empty is recorded at the next clock edge. The status word then reads back as follows:
  - Bit 28: 1, marking a recorded violation.
  - Bit 27: 1 if the access was a write.
  - Bits 15:0: the access identifier.
  - All other bits: 0.
- R8: While a violation is recorded, later denied accesses leave the status word unchanged.
- R9: Writing the status word with bit 24 set empties it, so it reads back as 0. This clear wins over a denied access in the same cycle. A write to the status word with bit 24 at 0 changes nothing.
- R10: After reset, every window spans only address 0 with all rules 0. Every register reads back as 0, and every access is allowed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 12 | Register byte address |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Register read data for regAddr |
| accValid | input | 1 | Access present this cycle |
| accAddr | input | 32 | Access address |
| accDomain | input | 3 | Requester domain |
| accWrite | input | 1 | 1 = write, 0 = read |
| accSecure | input | 1 | 1 = secure access |
| accId | input | 16 | Access identifier |
| accAllow | output | 1 | Access decision (1 = allow) |

## Verification
Every one of the eight rule codes is applied to all four combinations of secure/non-secure and read/write. A neighbouring domain is given a different rule at the same time, so a misplaced field or a swapped row of the rule table shows up as a mismatch.

Probes one below, exactly at, and one above each bound separate inclusive comparisons from strict ones. Overlapping windows with opposite rules expose a priority inversion. Back-to-back violations, a clear in the same cycle as a violation, and a status write with the clear bit at 0 distinguish first-capture behaviour from overwrite behaviour. Writes aimed at a frozen window show whether the freeze flag guards all three of its registers.

// File: rtl/guardPkg.sv
package guardPkg;
  localparam int REGIONS  = 24;
  localparam int DOMAINS  = 8;
  localparam int ADDR_W   = 32;
  localparam int DATA_W   = 32;
  localparam int ID_W     = 16;
  localparam int CODE_W   = 3;
  localparam int DOM_W    = $clog2(DOMAINS);
  localparam int REG_AW   = 12;
  localparam int SLOT_W   = 6;
  localparam int LOCK_BIT = 26;
  localparam int ST_CLEAR = 24;
  localparam int ST_WRITE = 27;
  localparam int ST_VIOL  = 28;
  localparam logic [DATA_W-1:0] POLICY_MASK =
    DATA_W'((1 << LOCK_BIT) | ((1 << (CODE_W * DOMAINS)) - 1));

  localparam logic [3:0] PAGE_STATUS = 4'h0;
  localparam logic [3:0] PAGE_LOWER  = 4'h1;
  localparam logic [3:0] PAGE_UPPER  = 4'h2;
  localparam logic [3:0] PAGE_POLICY = 4'h3;

  typedef enum logic [CODE_W-1:0] {
    RULE_OPEN      = 3'd0,
    RULE_SEC_ONLY  = 3'd1,
    RULE_SEC_NSRD  = 3'd2,
    RULE_SEC_NSWR  = 3'd3,
    RULE_READ_ONLY = 3'd4,
    RULE_BLOCKED   = 3'd5,
    RULE_SRD_NSRW  = 3'd6,
    RULE_RESERVED  = 3'd7
  } rule_e;

  typedef struct packed {
    logic              wrLower;
    logic              wrUpper;
    logic              wrPolicy;
    logic [SLOT_W-1:0] slot;
  } tableStrobe_t;

  function automatic logic ruleGrants(logic [CODE_W-1:0] code, logic secure, logic write);
    logic ok;
    case (rule_e'(code))
      RULE_OPEN:      ok = 1'b1;
      RULE_SEC_ONLY:  ok = secure;
      RULE_SEC_NSRD:  ok = secure | ~write;
      RULE_SEC_NSWR:  ok = secure | write;
      RULE_READ_ONLY: ok = ~write;
      RULE_SRD_NSRW:  ok = ~secure | ~write;
      default:        ok = 1'b0;
    endcase
    return ok;
  endfunction
endpackage

// File: rtl/guardDatapath.sv
module guardDatapath
  import guardPkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  tableStrobe_t        strobe,
  input  logic [DATA_W-1:0]   wrData,
  input  logic [ADDR_W-1:0]   accAddr,
  input  logic [DOM_W-1:0]    accDomain,
  input  logic                accWrite,
  input  logic                accSecure,
  output logic                accAllow,
  output logic [DATA_W-1:0]   rdLower,
  output logic [DATA_W-1:0]   rdUpper,
  output logic [DATA_W-1:0]   rdPolicy
);
  logic [ADDR_W-1:0] lowerQ  [REGIONS];
  logic [ADDR_W-1:0] upperQ  [REGIONS];
  logic [DATA_W-1:0] policyQ [REGIONS];
  logic [REGIONS-1:0] hitVec, lockVec, winVec;
  logic [CODE_W-1:0] selCode;

  // table storage; a frozen window ignores all three writes
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int r = 0; r < REGIONS; r++) begin
        lowerQ[r]  <= '0;
        upperQ[r]  <= '0;
        policyQ[r] <= '0;
      end
    end else begin
      for (int r = 0; r < REGIONS; r++) begin
        if (strobe.slot == SLOT_W'(r) && !lockVec[r]) begin
          if (strobe.wrLower)  lowerQ[r]  <= wrData[ADDR_W-1:0];
          if (strobe.wrUpper)  upperQ[r]  <= wrData[ADDR_W-1:0];
          if (strobe.wrPolicy) policyQ[r] <= wrData & POLICY_MASK;
        end
      end
    end
  end

  // window compare and lowest-index selection
  always_comb begin
    logic found;
    found   = 1'b0;
    winVec  = '0;
    selCode = '0;
    for (int r = 0; r < REGIONS; r++) begin
      lockVec[r] = policyQ[r][LOCK_BIT];
      hitVec[r]  = (lowerQ[r] <= accAddr) && (accAddr <= upperQ[r]);
      if (hitVec[r] && !found) begin
        winVec[r] = 1'b1;
        found     = 1'b1;
        selCode   = policyQ[r][CODE_W*int'(accDomain) +: CODE_W];
      end
    end
  end

  assign accAllow = (hitVec == '0) || ruleGrants(selCode, accSecure, accWrite);

  always_comb begin
    rdLower  = '0;
    rdUpper  = '0;
    rdPolicy = '0;
    if (int'(strobe.slot) < REGIONS) begin
      rdLower  = DATA_W'(lowerQ[strobe.slot[$clog2(REGIONS)-1:0]]);
      rdUpper  = DATA_W'(upperQ[strobe.slot[$clog2(REGIONS)-1:0]]);
      rdPolicy = policyQ[strobe.slot[$clog2(REGIONS)-1:0]];
    end
  end

  assert_single_winner_R2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(winVec));
  assert_no_lower_hit_R2: assert property (@(posedge clk) disable iff (!rstN)
    (winVec != '0) |-> ((hitVec & (winVec - 1'b1)) == '0));

  for (genvar g = 0; g < REGIONS; g++) begin : gChk
    assert_frozen_window_R6: assert property (@(posedge clk) disable iff (!rstN)
      lockVec[g] |=> ($stable(lowerQ[g]) && $stable(upperQ[g]) && $stable(policyQ[g])));
    assert_lower_written_R5: assert property (@(posedge clk) disable iff (!rstN)
      (strobe.wrLower && strobe.slot == SLOT_W'(g) && !lockVec[g])
        |=> (lowerQ[g] == $past(wrData[ADDR_W-1:0])));
  end
endmodule

// File: rtl/guardControl.sv
module guardControl
  import guardPkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                regWrEn,
  input  logic [REG_AW-1:0]   regAddr,
  input  logic [DATA_W-1:0]   regWrData,
  input  logic                accValid,
  input  logic                accAllow,
  input  logic                accWrite,
  input  logic [ID_W-1:0]     accId,
  input  logic [DATA_W-1:0]   rdLower,
  input  logic [DATA_W-1:0]   rdUpper,
  input  logic [DATA_W-1:0]   rdPolicy,
  output tableStrobe_t        strobe,
  output logic [DATA_W-1:0]   regRdData
);
  logic [3:0]        page;
  logic [SLOT_W-1:0] slot;
  logic              slotOk, statusHit, clearReq, capture;
  logic              violQ, violWrQ;
  logic [ID_W-1:0]   violIdQ;

  assign page      = regAddr[REG_AW-1:REG_AW-4];
  assign slot      = regAddr[SLOT_W+1:2];
  assign slotOk    = int'(slot) < REGIONS;
  assign statusHit = (page == PAGE_STATUS) && (regAddr[7:0] == 8'h00);

  assign strobe.slot     = slot;
  assign strobe.wrLower  = regWrEn && slotOk && page == PAGE_LOWER;
  assign strobe.wrUpper  = regWrEn && slotOk && page == PAGE_UPPER;
  assign strobe.wrPolicy = regWrEn && slotOk && page == PAGE_POLICY;

  assign clearReq = regWrEn && statusHit && regWrData[ST_CLEAR];
  assign capture  = accValid && !accAllow && !violQ && !clearReq;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      violQ   <= 1'b0;
      violWrQ <= 1'b0;
      violIdQ <= '0;
    end else if (clearReq) begin
      violQ   <= 1'b0;
      violWrQ <= 1'b0;
      violIdQ <= '0;
    end else if (capture) begin
      violQ   <= 1'b1;
      violWrQ <= accWrite;
      violIdQ <= accId;
    end
  end

  always_comb begin
    regRdData = '0;
    if (statusHit) begin
      regRdData[ST_VIOL]    = violQ;
      regRdData[ST_WRITE]   = violWrQ;
      regRdData[ID_W-1:0]   = violIdQ;
    end else if (slotOk) begin
      case (page)
        PAGE_LOWER:  regRdData = rdLower;
        PAGE_UPPER:  regRdData = rdUpper;
        PAGE_POLICY: regRdData = rdPolicy;
        default:     regRdData = '0;
      endcase
    end
  end

  assert_first_capture_R7: assert property (@(posedge clk) disable iff (!rstN)
    (accValid && !accAllow && !violQ && !clearReq)
      |=> (violQ && violIdQ == $past(accId) && violWrQ == $past(accWrite)));
  assert_hold_record_R8: assert property (@(posedge clk) disable iff (!rstN)
    (violQ && !clearReq) |=> (violQ && $stable(violIdQ) && $stable(violWrQ)));
  assert_clear_wins_R9: assert property (@(posedge clk) disable iff (!rstN)
    clearReq |=> (!violQ && violIdQ == '0));
  assert_no_spurious_R7: assert property (@(posedge clk) disable iff (!rstN)
    (!violQ && !(accValid && !accAllow)) |=> !violQ);
endmodule

// File: rtl/regionGuard.sv
module regionGuard
  import guardPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [11:0]       regAddr,
  input  logic [31:0]       regWrData,
  output logic [31:0]       regRdData,
  input  logic              accValid,
  input  logic [31:0]       accAddr,
  input  logic [2:0]        accDomain,
  input  logic              accWrite,
  input  logic              accSecure,
  input  logic [15:0]       accId,
  output logic              accAllow
);
  tableStrobe_t      strobe;
  logic [DATA_W-1:0] rdLower, rdUpper, rdPolicy;

  guardControl uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .regWrEn   (regWrEn),
    .regAddr   (regAddr),
    .regWrData (regWrData),
    .accValid  (accValid),
    .accAllow  (accAllow),
    .accWrite  (accWrite),
    .accId     (accId),
    .rdLower   (rdLower),
    .rdUpper   (rdUpper),
    .rdPolicy  (rdPolicy),
    .strobe    (strobe),
    .regRdData (regRdData)
  );

  guardDatapath uPath (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .wrData    (regWrData),
    .accAddr   (accAddr),
    .accDomain (accDomain),
    .accWrite  (accWrite),
    .accSecure (accSecure),
    .accAllow  (accAllow),
    .rdLower   (rdLower),
    .rdUpper   (rdUpper),
    .rdPolicy  (rdPolicy)
  );
endmodule

// File: tb/sim_regionGuard.sv
`timescale 1ns/1ps
module sim_regionGuard;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [11:0] regAddr = '0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        accValid = 1'b0;
  logic [31:0] accAddr = '0;
  logic [2:0]  accDomain = '0;
  logic        accWrite = 1'b0;
  logic        accSecure = 1'b0;
  logic [15:0] accId = '0;
  logic        accAllow;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  regionGuard u0 (.*);

  // behavioural reference
  longint mLo [24];
  longint mHi [24];
  int unsigned mPol [24];
  bit mViol;
  bit mWr;
  int unsigned mId;

  // rights per rule as {secRead, secWrite, nsRead, nsWrite}
  function automatic bit rightOf(int code, bit sec, bit wr);
    bit [3:0] rights [8] = '{4'b1111, 4'b1100, 4'b1110, 4'b1101,
                             4'b1010, 4'b0000, 4'b1011, 4'b0000};
    int pos;
    pos = (sec ? 3 : 1) - (wr ? 1 : 0);
    return rights[code][pos];
  endfunction

  function automatic bit mAllow(longint a, int dom, bit wr, bit sec);
    for (int r = 0; r < 24; r++)
      if (mLo[r] <= a && a <= mHi[r])
        return rightOf(int'((mPol[r] >> (3 * dom)) & 7), sec, wr);
    return 1'b1;
  endfunction

  function automatic logic [31:0] mRead(logic [11:0] a);
    int pg = int'(a[11:8]);
    int sl = int'(a[7:2]);
    if (pg == 0 && a[7:0] == 0) return {3'b0, mViol, mWr, 11'b0, mId[15:0]};
    if (sl >= 24) return 32'h0;
    if (pg == 1) return 32'(mLo[sl]);
    if (pg == 2) return 32'(mHi[sl]);
    if (pg == 3) return mPol[sl];
    return 32'h0;
  endfunction

  task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // one clock: drive at negedge, compare, then advance the model at posedge
  task automatic step(string tag, bit rEn, logic [11:0] rA, logic [31:0] rD,
                      bit aV, logic [31:0] aA, int dom, bit wr, bit sec, logic [15:0] id);
    bit expAllow, clr;
    int sl;
    @(negedge clk);
    regWrEn = rEn; regAddr = rA; regWrData = rD;
    accValid = aV; accAddr = aA; accDomain = 3'(dom);
    accWrite = wr; accSecure = sec; accId = id;
    #2;
    expAllow = mAllow(longint'(aA), dom, wr, sec);
    check(tag, "allow", 32'(accAllow), 32'(expAllow));
    check(tag, "read", regRdData, mRead(rA));
    @(posedge clk);
    clr = rEn && rA == 12'h000 && rD[24];
    if (clr) begin
      mViol = 0; mWr = 0; mId = 0;
    end else if (aV && !expAllow && !mViol) begin
      mViol = 1; mWr = wr; mId = id;
    end
    sl = int'(rA[7:2]);
    if (rEn && sl < 24 && !mPol[sl][26]) begin
      case (rA[11:8])
        4'h1: mLo[sl] = longint'(rD);
        4'h2: mHi[sl] = longint'(rD);
        4'h3: mPol[sl] = rD & 32'h04FF_FFFF;
        default: ;
      endcase
    end
  endtask

  task automatic wreg(string tag, logic [11:0] a, logic [31:0] d);
    step(tag, 1, a, d, 0, 32'h0, 0, 0, 0, 16'h0);
  endtask
  task automatic rreg(string tag, logic [11:0] a);
    step(tag, 0, a, 32'h0, 0, 32'h0, 0, 0, 0, 16'h0);
  endtask
  task automatic acc(string tag, logic [31:0] a, int dom, bit wr, bit sec, logic [15:0] id);
    step(tag, 0, 12'h000, 32'h0, 1, a, dom, wr, sec, id);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int r = 0; r < 24; r++) begin mLo[r] = 0; mHi[r] = 0; mPol[r] = 0; end
    mViol = 0; mWr = 0; mId = 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R10: reset contents
    rreg("R10", 12'h000);
    rreg("R10", 12'h100);
    rreg("R10", 12'h25C);
    rreg("R10", 12'h35C);
    acc("R10", 32'h0, 0, 1, 0, 16'h0001);
    acc("R10", 32'h1234, 5, 1, 0, 16'h0002);

    // R5: map and readback, with masked policy bits
    wreg("R5", 12'h100, 32'h0000_1000);
    wreg("R5", 12'h200, 32'h0000_1FFF);
    wreg("R5", 12'h35C, 32'hFBFF_FFFF);
    rreg("R5", 12'h100);
    rreg("R5", 12'h200);
    rreg("R5", 12'h35C);
    wreg("R5", 12'h35C, 32'h0);

    // R4: every rule against all secure/direction pairs; domain 2 holds rule 5
    for (int code = 0; code < 8; code++) begin
      wreg("R4", 12'h300, (32'(code) << 9) | (32'd5 << 6));
      for (int k = 0; k < 4; k++) begin
        acc("R4", 32'h1800, 3, k[0], k[1], 16'(16'h4000 + code * 4 + k));
        wreg("R4", 12'h000, 32'h0100_0000);
      end
      acc("R4", 32'h1800, 2, 0, 1, 16'h00AA);
      wreg("R4", 12'h000, 32'h0100_0000);
    end

    // R1 / R3: bound probes with rule 5 for domain 3
    wreg("R1", 12'h300, 32'd5 << 9);
    acc("R3", 32'h0FFF, 3, 0, 1, 16'h0101);
    acc("R1", 32'h1000, 3, 0, 1, 16'h0102);
    wreg("R1", 12'h000, 32'h0100_0000);
    acc("R1", 32'h1FFF, 3, 1, 0, 16'h0103);
    wreg("R1", 12'h000, 32'h0100_0000);
    acc("R3", 32'h2000, 3, 1, 0, 16'h0104);

    // R2: overlap; window 1 open over 0x1800..0x27FF, window 5 blocked over it too
    wreg("R2", 12'h104, 32'h0000_1800);
    wreg("R2", 12'h204, 32'h0000_27FF);
    wreg("R2", 12'h304, 32'h0);
    wreg("R2", 12'h114, 32'h0000_1800);
    wreg("R2", 12'h214, 32'h0000_2FFF);
    wreg("R2", 12'h314, 32'd5 << 9);
    acc("R2", 32'h1900, 3, 0, 1, 16'h0201);
    wreg("R2", 12'h000, 32'h0100_0000);
    acc("R2", 32'h2100, 3, 1, 0, 16'h0202);
    acc("R2", 32'h2900, 3, 1, 0, 16'h0203);
    rreg("R2", 12'h000);
    wreg("R2", 12'h000, 32'h0100_0000);

    // R7 / R8: first violation kept
    acc("R7", 32'h1100, 3, 1, 1, 16'hBEEF);
    rreg("R7", 12'h000);
    acc("R8", 32'h1200, 3, 0, 0, 16'h1234);
    rreg("R8", 12'h000);

    // R9: clear bit at 0 is ignored; clear beats a same-cycle violation
    wreg("R9", 12'h000, 32'hFEFF_FFFF);
    rreg("R9", 12'h000);
    step("R9", 1, 12'h000, 32'h0100_0000, 1, 32'h1300, 3, 1, 0, 16'h5555);
    rreg("R9", 12'h000);
    acc("R9", 32'h1300, 3, 0, 0, 16'h7777);
    rreg("R9", 12'h000);
    wreg("R9", 12'h000, 32'h0100_0000);

    // R6: freeze window 4, then try to rewrite it
    wreg("R6", 12'h110, 32'h0000_8000);
    wreg("R6", 12'h210, 32'h0000_8FFF);
    wreg("R6", 12'h310, (32'd1 << 26) | (32'd4 << 9));
    wreg("R6", 12'h110, 32'h0000_0000);
    wreg("R6", 12'h210, 32'hFFFF_FFFF);
    wreg("R6", 12'h310, 32'h0);
    rreg("R6", 12'h110);
    rreg("R6", 12'h210);
    rreg("R6", 12'h310);
    acc("R6", 32'h8800, 3, 0, 0, 16'h0601);
    acc("R6", 32'h8800, 3, 1, 0, 16'h0602);
    rreg("R6", 12'h000);

    @(negedge clk);
    regWrEn = 0; accValid = 0;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule